// File: doc/BRIEF.md
# Thread Issue Picker with Monitor-Wait Sleep

This block sits at the front of a shallow in-order pipeline shared by four hardware thread contexts. Every cycle it chooses at most one context to issue, rotating fairly among the contexts that can make progress. A context is passed over while its stall flag is high, for example while it waits on a cache miss or on a long divide.

A context can also park itself with a monitor-wait. It presents its thread number and a memory address, then sleeps. A sleeping context is never chosen, so a thread spinning on a lock takes no issue slots away from its siblings. The block snoops the store-address bus. A store to the same 64-byte line as the armed address returns the context to the pool. Each context carries a two-state machine: `CTX_RUN` (awake) and `CTX_SLEEP` (parked). The transitions are: `ARM`, from `CTX_RUN` to `CTX_SLEEP` on a monitor-wait; `WAKE`, from `CTX_SLEEP` to `CTX_RUN` on a matching store; and `ARM_CANCEL`, which keeps the context in `CTX_RUN` when the arming and a matching store fall in the same cycle.

Top module: `thread_issue_picker`

## Requirements
- R1: `grant_o` has at most one bit set, and `grant_vld_o` is high exactly when a bit of `grant_o` is set; bit t of `grant_o` selects thread t.
- R2: After a grant to thread i, the next grant goes to the first eligible thread found searching (i+1) mod 4, (i+2) mod 4, and so on; a thread is eligible when it is awake and its `stall_i` bit is low.
- R3: A thread whose `stall_i` bit is high is not granted in that cycle, and the rotation continues over the remaining threads.
- R4: When no thread is eligible, `grant_vld_o` is low, `grant_o` is zero and the rotation start point is kept for the next cycle.
- R5: A cycle with `mwait_vld_i` high, thread number `mwait_tid_i` (2 bits) and address `mwait_addr_i` puts an awake thread to sleep from the next cycle on; a sleeping thread is never granted.
- R6: A store (`store_vld_i` high) whose `store_addr_i` bits [31:6] equal bits [31:6] of a sleeping thread's armed address wakes that thread, which is eligible from the next cycle; address bits [5:0] play no part.
- R7: A store to a different 64-byte line leaves a sleeping thread asleep.
- R8: When a monitor-wait and a store to the same line arrive in the same cycle, the thread stays awake.
- R9: A monitor-wait for a thread that is already asleep is ignored; the thread keeps its first armed address.
- R10: Reset puts every thread in the awake state, clears the armed addresses and sets the rotation start to thread 0.
- R11: One store wakes every thread sleeping on that line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stall_i | input | 4 | Per-thread stall flags, bit t for thread t |
| mwait_vld_i | input | 1 | Monitor-wait request this cycle |
| mwait_tid_i | input | 2 | Thread issuing the monitor-wait |
| mwait_addr_i | input | 32 | Address to monitor |
| store_vld_i | input | 1 | A store is seen on the snoop bus |
| store_addr_i | input | 32 | Address of the snooped store |
| grant_o | output | 4 | One-hot issue grant |
| grant_vld_o | output | 1 | A thread was granted this cycle |

## Verification
The rotation is swept through every one of the sixteen stall patterns in changing orders. This covers every start point of the search and sets a wrapping search apart from a fixed-priority one; the all-stalled pattern shows whether the start point holds. Sleep is tried with stores to the exact armed address, to the same line at a different offset and to another line. This separates line matching from full-address matching and from no matching. Same-cycle arm-and-store, a second arm on a sleeping thread, and two threads sharing one line expose lost wake-ups, overwritten addresses and single-thread wake-up. A long mixed run with computed stalls, arms and stores is compared against a model in the bench, and a reset in mid-run checks that sleep is cleared.

// File: rtl/tip_pkg.sv
package tip_pkg;

    typedef enum logic {
        CTX_RUN   = 1'b0,
        CTX_SLEEP = 1'b1
    } ctx_state_e;

endpackage

// File: rtl/tip_thread_ctx.sv
module tip_thread_ctx
    import tip_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_i,
    input  logic [ADDR_W-1:0] arm_addr_i,
    input  logic              st_vld_i,
    input  logic [ADDR_W-1:0] st_addr_i,
    output logic              asleep_o
);

    localparam logic [ADDR_W-1:0] LINE_MASK = ~((ADDR_W'(1) << LINE_LSB) - ADDR_W'(1));

    ctx_state_e        state_q, state_d;
    logic [ADDR_W-1:0] watch_q, watch_d;
    logic              snoop_hit;
    logic              arm_hit;

    // store against the parked address, and against the address being armed
    assign snoop_hit = st_vld_i && (((st_addr_i ^ watch_q) & LINE_MASK) == '0);
    assign arm_hit   = st_vld_i && (((st_addr_i ^ arm_addr_i) & LINE_MASK) == '0);

    always_comb begin
        state_d = state_q;
        watch_d = watch_q;
        unique case (state_q)
            CTX_RUN: begin
                if (arm_i && !arm_hit) begin      // ARM
                    state_d = CTX_SLEEP;
                    watch_d = arm_addr_i & LINE_MASK;
                end                               // ARM_CANCEL otherwise
            end
            CTX_SLEEP: begin
                if (snoop_hit) begin              // WAKE
                    state_d = CTX_RUN;
                    watch_d = '0;
                end
            end
            default: begin
                state_d = CTX_RUN;
                watch_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CTX_RUN;
            watch_q <= '0;
        end else begin
            state_q <= state_d;
            watch_q <= watch_d;
        end
    end

    always_comb begin
        unique case (state_q)
            CTX_RUN:   asleep_o = 1'b0;
            CTX_SLEEP: asleep_o = 1'b1;
            default:   asleep_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/tip_rr_pick.sv
module tip_rr_pick #(
    parameter int NT    = 4,
    localparam int TID_W = $clog2(NT)
) (
    input  logic [NT-1:0]    elig_i,
    input  logic [TID_W-1:0] start_i,
    output logic [NT-1:0]    grant_o,
    output logic             vld_o,
    output logic [TID_W-1:0] idx_o
);

    always_comb begin
        logic [TID_W-1:0] cand;
        vld_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < NT; k++) begin
            cand = start_i + TID_W'(k);
            if (!vld_o && elig_i[cand]) begin
                vld_o = 1'b1;
                idx_o = cand;
            end
        end
        grant_o = vld_o ? (NT'(1) << idx_o) : '0;
    end

endmodule

// File: rtl/thread_issue_picker.sv
module thread_issue_picker #(
    parameter int NT       = 4,
    parameter int ADDR_W   = 32,
    parameter int LINE_LSB = 6,
    localparam int TID_W   = $clog2(NT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NT-1:0]     stall_i,
    input  logic              mwait_vld_i,
    input  logic [TID_W-1:0]  mwait_tid_i,
    input  logic [ADDR_W-1:0] mwait_addr_i,
    input  logic              store_vld_i,
    input  logic [ADDR_W-1:0] store_addr_i,
    output logic [NT-1:0]     grant_o,
    output logic              grant_vld_o
);

    logic [NT-1:0]    asleep;
    logic [NT-1:0]    elig;
    logic [TID_W-1:0] ptr_q;
    logic [TID_W-1:0] gnt_idx;

    for (genvar t = 0; t < NT; t++) begin : g_ctx
        tip_thread_ctx #(
            .ADDR_W   (ADDR_W),
            .LINE_LSB (LINE_LSB)
        ) u_ctx (
            .clk        (clk),
            .rst_n      (rst_n),
            .arm_i      (mwait_vld_i && (mwait_tid_i == TID_W'(t))),
            .arm_addr_i (mwait_addr_i),
            .st_vld_i   (store_vld_i),
            .st_addr_i  (store_addr_i),
            .asleep_o   (asleep[t])
        );
    end

    assign elig = ~stall_i & ~asleep;

    tip_rr_pick #(
        .NT (NT)
    ) u_pick (
        .elig_i  (elig),
        .start_i (ptr_q),
        .grant_o (grant_o),
        .vld_o   (grant_vld_o),
        .idx_o   (gnt_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (grant_vld_o) begin
            ptr_q <= gnt_idx + TID_W'(1);
        end
    end

endmodule

// File: rtl/tip_picker_chk.sv
module tip_picker_chk #(
    parameter int NT    = 4,
    localparam int TID_W = $clog2(NT)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NT-1:0]    stall_i,
    input logic             mwait_vld_i,
    input logic [TID_W-1:0] mwait_tid_i,
    input logic             store_vld_i,
    input logic [NT-1:0]    grant_o,
    input logic             grant_vld_o,
    input logic [NT-1:0]    elig,
    input logic [TID_W-1:0] ptr_q
);

    logic             seen_q;
    logic [TID_W-1:0] succ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            succ_q <= '0;
        end else begin
            seen_q <= grant_vld_o;
            if (grant_vld_o) begin
                for (int t = 0; t < NT; t++) begin
                    if (grant_o[t]) succ_q <= TID_W'(t) + TID_W'(1);
                end
            end
        end
    end

    // R1
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o) && (grant_vld_o == (grant_o != '0)));

    // R2
    rotation_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q && elig[succ_q] |-> grant_o[succ_q]);

    // R3
    stall_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & stall_i) == '0);

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !grant_vld_o |=> ptr_q == $past(ptr_q));

    // R5
    sleep_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mwait_vld_i && !store_vld_i |=> grant_o[$past(mwait_tid_i)] == 1'b0);

endmodule

bind thread_issue_picker tip_picker_chk #(.NT(NT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stall_i     (stall_i),
    .mwait_vld_i (mwait_vld_i),
    .mwait_tid_i (mwait_tid_i),
    .store_vld_i (store_vld_i),
    .grant_o     (grant_o),
    .grant_vld_o (grant_vld_o),
    .elig        (elig),
    .ptr_q       (ptr_q)
);

// File: tb/sim_thread_issue_picker.sv
module sim_thread_issue_picker;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  stall_i = '0;
    logic        mwait_vld_i = 1'b0;
    logic [1:0]  mwait_tid_i = '0;
    logic [31:0] mwait_addr_i = '0;
    logic        store_vld_i = 1'b0;
    logic [31:0] store_addr_i = '0;
    logic [3:0]  grant_o;
    logic        grant_vld_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    bit          m_sleep [4];
    logic [25:0] m_line  [4];
    int          m_ptr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    thread_issue_picker u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .stall_i      (stall_i),
        .mwait_vld_i  (mwait_vld_i),
        .mwait_tid_i  (mwait_tid_i),
        .mwait_addr_i (mwait_addr_i),
        .store_vld_i  (store_vld_i),
        .store_addr_i (store_addr_i),
        .grant_o      (grant_o),
        .grant_vld_o  (grant_vld_o)
    );

    task automatic model_reset();
        for (int t = 0; t < 4; t++) begin
            m_sleep[t] = 0;
            m_line[t]  = '0;
        end
        m_ptr = 0;
    endtask

    function automatic logic [4:0] expect_grant(input logic [3:0] st);
        for (int k = 0; k < 4; k++) begin
            int c;
            c = (m_ptr + k) % 4;
            if (!st[c] && !m_sleep[c]) return {1'b1, 4'(1 << c)};
        end
        return 5'b0;
    endfunction

    // one cycle: drive, check before the edge, advance the model at the edge
    task automatic cyc(input logic [3:0] st, input logic mv, input logic [1:0] mt,
                       input logic [31:0] ma, input logic sv, input logic [31:0] sa,
                       input string tag);
        logic [4:0] exp;
        bit         old_sleep [4];
        stall_i = st; mwait_vld_i = mv; mwait_tid_i = mt; mwait_addr_i = ma;
        store_vld_i = sv; store_addr_i = sa;
        #1;
        exp = expect_grant(st);
        checks++;
        if ({grant_vld_o, grant_o} !== exp) begin
            errors++;
            $display("FAIL %s: vld/grant actual=%b/%b expected=%b/%b",
                     tag, grant_vld_o, grant_o, exp[4], exp[3:0]);
        end
        @(posedge clk);
        for (int t = 0; t < 4; t++) old_sleep[t] = m_sleep[t];
        if (exp[4]) begin
            for (int t = 0; t < 4; t++) if (exp[t]) m_ptr = (t + 1) % 4;
        end
        for (int t = 0; t < 4; t++) begin
            if (old_sleep[t] && sv && sa[31:6] == m_line[t]) begin
                m_sleep[t] = 0;
                m_line[t]  = '0;
            end
        end
        if (mv && !old_sleep[mt] && !(sv && sa[31:6] == ma[31:6])) begin
            m_sleep[mt] = 1;
            m_line[mt]  = ma[31:6];
        end
        @(negedge clk);
    endtask

    task automatic idle(input logic [3:0] st, input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(st, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R10: awake, start at thread 0
        idle(4'b0000, 1, "R10");
        // R2: plain rotation
        idle(4'b0000, 8, "R2");
        // R3: sweep of all stall patterns in shifting orders
        for (int i = 0; i < 256; i++) begin
            cyc(4'((i * 7 + (i >> 4) * 3) & 15), 0, 0, 0, 0, 0, "R3");
        end
        // R4: nothing eligible holds the start point
        idle(4'b1101, 1, "R4");
        idle(4'b1111, 3, "R4");
        idle(4'b0000, 4, "R4");
        // R5: thread 2 parks on 0x1000
        cyc(4'b0000, 1, 2'd2, 32'h0000_1000, 0, 0, "R5");
        idle(4'b0000, 8, "R5");
        idle(4'b1011, 2, "R5");
        // R7: store to a different line
        cyc(4'b0000, 0, 0, 0, 1, 32'h0000_2000, "R7");
        idle(4'b1011, 2, "R7");
        // R6: same line, other offset
        cyc(4'b0000, 0, 0, 0, 1, 32'h0000_103F, "R6");
        idle(4'b1011, 2, "R6");
        idle(4'b0000, 4, "R6");
        // R8: arm with matching store in the same cycle
        cyc(4'b0000, 1, 2'd0, 32'h0000_3000, 1, 32'h0000_3010, "R8");
        idle(4'b1110, 2, "R8");
        // R9: second arm on a sleeping thread is ignored
        cyc(4'b0000, 1, 2'd1, 32'h0000_4000, 0, 0, "R9");
        cyc(4'b0000, 1, 2'd1, 32'h0000_5000, 0, 0, "R9");
        cyc(4'b0000, 0, 0, 0, 1, 32'h0000_5000, "R9");
        idle(4'b1101, 2, "R9");
        cyc(4'b0000, 0, 0, 0, 1, 32'h0000_4008, "R9");
        idle(4'b1101, 2, "R9");
        // R11: two sleepers on one line
        cyc(4'b0000, 1, 2'd0, 32'h0000_6000, 0, 0, "R11");
        cyc(4'b0000, 1, 2'd3, 32'h0000_6020, 0, 0, "R11");
        idle(4'b0110, 2, "R11");
        cyc(4'b0110, 0, 0, 0, 1, 32'h0000_6004, "R11");
        idle(4'b0110, 4, "R11");
        // R5: long mixed run of stalls, arms and stores over four lines
        lfsr = 32'h1234_5678;
        for (int i = 0; i < 600; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            cyc(lfsr[3:0] & lfsr[7:4], lfsr[8] & lfsr[9], lfsr[11:10],
                {24'h0, lfsr[13:12], lfsr[19:14]}, lfsr[20] & lfsr[21],
                {24'h0, lfsr[23:22], lfsr[29:24]}, "R5");
        end
        // R10: reset in mid-run clears sleep and the start point
        cyc(4'b0000, 1, 2'd2, 32'h0000_0040, 0, 0, "R10");
        idle(4'b0000, 1, "R10");
        rst_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1'b1;
        idle(4'b0000, 1, "R10");
        idle(4'b1011, 1, "R10");
        // R1: outputs stay consistent over a short random tail
        for (int i = 0; i < 32; i++) cyc(4'(i ^ (i >> 2)), 0, 0, 0, 0, 0, "R1");

        finish_run();
    end

endmodule